// File: doc/BRIEF.md
# Zero-turnaround pipelined synchronous SRAM

This block is a synthesizable single-port synchronous static memory. Address, control and write data are all registered. Every access takes the same fixed route: the command is sampled in cycle c and its data moves in cycle c+2. A read drives its word during cycle c+2. A write takes its word from the write-data bus at the end of cycle c+2. Because both directions use the same slot, a controller can issue reads and writes in any order on consecutive cycles and the data bus never needs an idle cycle to turn around.

A built-in burst sequencer generates three more addresses from one loaded address. It supports a linear order and an interleaved order. Writes can be limited to any subset of four byte lanes. Each lane holds 8 data bits and 1 parity bit. A clock-enable input freezes the whole block, and three chip selects gate new commands. An asynchronous output enable can silence the read-data port at any time. The bidirectional data bus of a board-level part is modelled here as two buses plus a drive flag: a write-data bus, a read-data bus and a drive enable.

A read issued one cycle after a write to the same word returns that write's new bytes. The pending data is merged lane by lane, so a read never returns stale contents.

Top module: `zbt_sram`

## Requirements
- R1: A command sampled at the end of cycle c has its data phase in cycle c+2, counting only cycles whose edge is not stalled. A read drives `rdata_oe`=1 and its word on `rdata` throughout that cycle. A write stores the `wdata` present at the end of that cycle.
- R2: When `stall`=1 at a rising edge, that edge has no effect. No command is taken, the pipeline and burst state hold, no write is stored, and `rdata`/`rdata_oe` keep their values.
- R3: The block is selected only when `cs_a_n`=0, `cs_b_n`=0 and `cs_c`=1. If any one of these is false, the block is deselected.
- R4: A deselected cycle with `adv`=0 starts no operation and ends any burst in progress. Operations already sampled still complete their data phase.
- R5: `rdata_oe` is 0 during the data phase of a write and during the data phase of a deselect.
- R6: The word is 36 bits. Lane n (n=0..3) covers data bits [8n+7:8n] and parity bit 32+n. `lane_we_n[n]`=0 enables lane n. Any combination of lanes may be written by one write, and disabled lanes keep their old contents.
- R7: `out_en_n`=1 forces `rdata_oe`=0 and `rdata`=0 at once, without a clock edge. It does not disturb the pipeline.
- R8: While `rst_n`=0 at a rising edge, `rdata_oe` is 0 after that edge, and no operation is pending.
- R9: `adv`=1 during an active burst issues the next burst address, using the direction fixed when the burst was loaded. `rnw` and the chip selects are ignored in that cycle. `lane_we_n` applies to burst writes. The four-beat sequence wraps.
- R10: Beat i (0..3) of a burst loaded at address a keeps bits above bit 1 of a. Its low two bits are (a+i) mod 4 when `lin_order`=1 and a XOR i when `lin_order`=0. `lin_order` is held constant during a burst.
- R11: A read whose command follows a write to the same address by one cycle returns the write's new bytes in its enabled lanes and the old memory bytes in the others.
- R12: `adv`=1 when no burst is active, either after reset or after a deselect, starts no operation.
- R13: Reads and writes may alternate on every cycle with no idle cycle and no data loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| stall | input | 1 | 1 = ignore this clock edge (clock enable, active low) |
| cs_a_n | input | 1 | Chip select A, active low |
| cs_b_n | input | 1 | Chip select B, active low |
| cs_c | input | 1 | Chip select C, active high |
| rnw | input | 1 | 1 = read, 0 = write (sampled on load) |
| lane_we_n | input | 4 | Per-lane write enables, active low |
| adv | input | 1 | 0 = load external address, 1 = advance burst |
| lin_order | input | 1 | 1 = linear burst order, 0 = interleaved |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| addr | input | 8 | Word address |
| wdata | input | 36 | Write data, taken in the write's data phase |
| rdata | output | 36 | Read data, zero when not driven |
| rdata_oe | output | 1 | Read data drive enable |

## Verification
Two functions can land in the same clock edge. The first is storing a write's data at the end of its data phase. The second is reading memory for the next command, which may be a read of the same word. The bench provokes this with directed write-then-read pairs using partial lane masks, and with random streams that draw addresses from a small pool. In both cases the returned word must show the freshly written lanes merged over the old ones. Burst advancing, stalls and asynchronous output gating are mixed into the same streams. Each data phase is judged against a bench memory model in which the write is applied before the read's word is taken.

// File: rtl/zbt_sram.sv
module zbt_burst_seq #(
  parameter int ADDR_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              load,
  input  logic              step,
  input  logic              linear,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] next_addr
);
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] cnt_q;
  logic [BURST_W-1:0] cnt_nx;
  logic [BURST_W-1:0] low;

  assign cnt_nx    = cnt_q + 1'b1;
  assign low       = linear ? base_q[BURST_W-1:0] + cnt_nx : base_q[BURST_W-1:0] ^ cnt_nx;
  assign next_addr = {base_q[ADDR_W-1:BURST_W], low};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (en) begin
      if (load) begin
        base_q <= addr_in;
        cnt_q  <= '0;
      end else if (step) begin
        cnt_q  <= cnt_nx;
      end
    end
  end
endmodule

module zbt_sram #(
  parameter int ADDR_W  = 8,
  parameter int LANES   = 4,
  parameter int LANE_DW = 8,
  parameter int BURST_W = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            stall,
  input  logic                            cs_a_n,
  input  logic                            cs_b_n,
  input  logic                            cs_c,
  input  logic                            rnw,
  input  logic [LANES-1:0]                lane_we_n,
  input  logic                            adv,
  input  logic                            lin_order,
  input  logic                            out_en_n,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [LANES*LANE_DW+LANES-1:0]  wdata,
  output logic [LANES*LANE_DW+LANES-1:0]  rdata,
  output logic                            rdata_oe
);
  localparam int DATA_W = LANES * LANE_DW;
  localparam int WORD_W = DATA_W + LANES;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  logic              sel, burst_act, burst_rd;
  logic              new_v, new_rd;
  logic [ADDR_W-1:0] new_addr, seq_addr;

  logic              s1_v, s1_rd, s2_v, s2_rd;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [LANES-1:0]  s1_bw, s2_bw;
  logic [WORD_W-1:0] s2_mask, rd_word, rd_merged, dout_q;
  logic              drive_q, commit, fwd;

  assign sel      = !cs_a_n && !cs_b_n && cs_c;
  assign new_v    = adv ? burst_act : sel;
  assign new_rd   = adv ? burst_rd  : rnw;
  assign new_addr = adv ? seq_addr  : addr;

  zbt_burst_seq #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (!stall),
    .load     (!adv),
    .step     (adv && burst_act),
    .linear   (lin_order),
    .addr_in  (addr),
    .next_addr(seq_addr)
  );

  genvar l;
  generate
    for (l = 0; l < LANES; l++) begin : g_lane
      assign s2_mask[l*LANE_DW +: LANE_DW] = {LANE_DW{s2_bw[l]}};
      assign s2_mask[DATA_W + l]           = s2_bw[l];
    end
  endgenerate

  assign commit    = s2_v && !s2_rd;
  assign fwd       = commit && (s2_addr == s1_addr);
  assign rd_word   = mem[s1_addr];
  assign rd_merged = fwd ? ((wdata & s2_mask) | (rd_word & ~s2_mask)) : rd_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v      <= 1'b0;
      s2_v      <= 1'b0;
      s1_rd     <= 1'b0;
      s2_rd     <= 1'b0;
      s1_addr   <= '0;
      s2_addr   <= '0;
      s1_bw     <= '0;
      s2_bw     <= '0;
      burst_act <= 1'b0;
      burst_rd  <= 1'b0;
      drive_q   <= 1'b0;
      dout_q    <= '0;
    end else if (!stall) begin
      s1_v    <= new_v;
      s1_rd   <= new_rd;
      s1_addr <= new_addr;
      s1_bw   <= ~lane_we_n;
      s2_v    <= s1_v;
      s2_rd   <= s1_rd;
      s2_addr <= s1_addr;
      s2_bw   <= s1_bw;
      drive_q <= s1_v && s1_rd;
      if (s1_v && s1_rd) dout_q <= rd_merged;
      if (!adv) begin
        burst_act <= sel;
        burst_rd  <= rnw;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && !stall && commit)
      mem[s2_addr] <= (mem[s2_addr] & ~s2_mask) | (wdata & s2_mask);
  end

  assign rdata_oe = drive_q && !out_en_n;
  assign rdata    = rdata_oe ? dout_q : '0;

  assert_rd_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !adv && sel && rnw) ##1 !stall |=> drive_q);

  assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(drive_q) && $stable(dout_q) && $stable(s1_v) && $stable(burst_act));

  assert_desel_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !adv && !sel) ##1 !stall |=> !drive_q);

  assert_write_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !adv && sel && !rnw) ##1 !stall |=> !drive_q);

  assert_idle_adv_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && adv && !burst_act) ##1 !stall |=> !drive_q);

  assert_reset_quiet_R8: assert property (@(posedge clk)
    !rst_n |=> !drive_q);
endmodule

// File: tb/sim_zbt_sram.sv
module sim_zbt_sram;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, stall, cs_a_n, cs_b_n, cs_c, rnw, adv, lin_order, out_en_n;
  logic [3:0]  lane_we_n;
  logic [7:0]  addr;
  logic [35:0] wdata, rdata;
  logic        rdata_oe;

  zbt_sram u0 (
    .clk(clk), .rst_n(rst_n), .stall(stall), .cs_a_n(cs_a_n), .cs_b_n(cs_b_n),
    .cs_c(cs_c), .rnw(rnw), .lane_we_n(lane_we_n), .adv(adv), .lin_order(lin_order),
    .out_en_n(out_en_n), .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  always #(PERIOD/2) clk = ~clk;

  int    n_cmp = 0, n_bad = 0;
  bit    done = 1'b0;
  string cur_req = "R8";

  logic [35:0] mmem [256];
  bit          m1_v, m1_rd, m2_v, m2_rd;
  logic [7:0]  m1_a, m2_a;
  logic [3:0]  m1_bw, m2_bw;
  bit          b_act, b_rd;
  logic [7:0]  b_base;
  logic [1:0]  b_cnt;
  bit          exp_drive = 1'b0;
  logic [35:0] exp_word = '0;

  function automatic logic [35:0] lane_mask(input logic [3:0] en);
    logic [35:0] m = '0;
    for (int n = 0; n < 4; n++) begin
      m[8*n +: 8] = {8{en[n]}};
      m[32+n]     = en[n];
    end
    return m;
  endfunction

  function automatic logic [7:0] beat_addr(input logic [7:0] base, input logic [1:0] i, input bit lin);
    logic [1:0] lo = lin ? base[1:0] + i : base[1:0] ^ i;
    return {base[7:2], lo};
  endfunction

  task automatic model_edge();
    bit nv, nrd; logic [7:0] na; logic [3:0] nbw;
    if (!rst_n) begin
      m1_v = 0; m2_v = 0; b_act = 0; exp_drive = 0;
      return;
    end
    if (stall) return;
    if (m2_v && !m2_rd) begin
      logic [35:0] mk = lane_mask(m2_bw);
      mmem[m2_a] = (mmem[m2_a] & ~mk) | (wdata & mk);
    end
    nbw = ~lane_we_n;
    if (!adv) begin
      bit s = !cs_a_n && !cs_b_n && cs_c;
      nv = s; nrd = rnw; na = addr;
      b_act = s; b_rd = rnw; b_base = addr; b_cnt = 0;
    end else if (b_act) begin
      b_cnt = b_cnt + 1'b1;
      nv = 1; nrd = b_rd; na = beat_addr(b_base, b_cnt, lin_order);
    end else begin
      nv = 0; nrd = 0; na = '0;
    end
    m2_v = m1_v; m2_rd = m1_rd; m2_a = m1_a; m2_bw = m1_bw;
    m1_v = nv; m1_rd = nrd; m1_a = na; m1_bw = nbw;
    exp_drive = m2_v && m2_rd;
    if (exp_drive) exp_word = mmem[m2_a];
  endtask

  task automatic check_out();
    bit          eo = exp_drive && !out_en_n;
    logic [35:0] ed = eo ? exp_word : '0;
    n_cmp++;
    if (rdata_oe !== eo || rdata !== ed) begin
      n_bad++;
      $display("FAIL %s t=%0t: rdata_oe=%0b rdata=%h expected rdata_oe=%0b rdata=%h",
               cur_req, $time, rdata_oe, rdata, eo, ed);
    end
  endtask

  task automatic tick();
    wdata = {4'($urandom), 32'($urandom)};
    @(posedge clk); #1;
    model_edge();
    @(negedge clk);
    check_out();
  endtask

  task automatic idle_in();
    stall = 0; cs_a_n = 0; cs_b_n = 0; cs_c = 1; rnw = 1; adv = 0;
    lane_we_n = 4'hF; out_en_n = 0; addr = '0;
  endtask

  task automatic load_op(input bit rd, input logic [7:0] a, input logic [3:0] we_n);
    idle_in(); rnw = rd; addr = a; lane_we_n = we_n; tick();
  endtask

  task automatic adv_op(input logic [3:0] we_n, input bit rw_noise);
    idle_in(); adv = 1; lane_we_n = we_n; rnw = rw_noise;
    cs_a_n = rw_noise; tick();
  endtask

  task automatic desel_op(input int which);
    idle_in(); adv = 0;
    case (which)
      0: cs_a_n = 1;
      1: cs_b_n = 1;
      default: cs_c = 0;
    endcase
    tick();
  endtask

  task automatic stall_op();
    idle_in(); stall = 1; addr = 8'($urandom); rnw = 1'($urandom); tick();
  endtask

  initial begin
    #(PERIOD*150000);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int seed = $urandom(32'd20240611);
    idle_in(); lin_order = 1; wdata = '0; rst_n = 0;
    m1_v = 0; m2_v = 0; b_act = 0;
    // R8: outputs quiet under reset
    cur_req = "R8";
    repeat (3) tick();
    rst_n = 1;
    idle_in(); adv = 1;
    cur_req = "R12";
    tick(); tick(); tick();

    // R1 and R13: fill memory with back-to-back writes
    cur_req = "R1";
    for (int a = 0; a < 256; a++) load_op(0, 8'(a), 4'h0);
    desel_op(2); desel_op(2);
    for (int a = 0; a < 16; a++) load_op(1, 8'(a*7), 4'hF);
    desel_op(0); desel_op(0);

    // R6 and R11: partial write then immediate read of the same word
    cur_req = "R6";
    for (int k = 0; k < 16; k++) begin
      load_op(0, 8'h40 + 8'(k), 4'(k));
      load_op(1, 8'h40 + 8'(k), 4'hF);
    end
    cur_req = "R11";
    for (int k = 0; k < 8; k++) begin
      load_op(0, 8'h20, 4'($urandom));
      load_op(1, 8'h20, 4'hF);
      load_op(1, 8'h20, 4'hF);
    end
    desel_op(1); desel_op(1);

    // R9 and R10: bursts in both orders, with wrap and rnw noise
    for (int o = 0; o < 2; o++) begin
      for (int b = 0; b < 4; b++) begin
        cur_req = (o == 0) ? "R10" : "R9";
        lin_order = 1'(o);
        load_op(1, 8'h90 + 8'(b), 4'hF);
        for (int i = 0; i < 6; i++) adv_op(4'hF, 1'(i));
      end
      load_op(0, 8'h64 + 8'(o), 4'h3);
      for (int i = 0; i < 3; i++) adv_op(4'(i + 5), 1);
      load_op(1, 8'h64, 4'hF);
      for (int i = 0; i < 3; i++) adv_op(4'hF, 0);
    end
    desel_op(0); desel_op(0);

    // R3, R4, R12: deselect by each chip select mid-burst, then advance
    for (int w = 0; w < 3; w++) begin
      cur_req = "R3";
      load_op(1, 8'hA1, 4'hF);
      adv_op(4'hF, 0);
      cur_req = "R4";
      desel_op(w);
      cur_req = "R12";
      adv_op(4'hF, 0); adv_op(4'hF, 1); adv_op(4'hF, 0);
    end

    // R2: stalls in the middle of pending reads and writes
    cur_req = "R2";
    load_op(0, 8'h33, 4'h0);
    stall_op(); stall_op();
    load_op(1, 8'h33, 4'hF);
    stall_op();
    load_op(1, 8'h34, 4'hF);
    stall_op(); stall_op(); stall_op();
    desel_op(2); desel_op(2);

    // R7: asynchronous output gating during read data phases
    cur_req = "R7";
    load_op(1, 8'h05, 4'hF);
    load_op(1, 8'h06, 4'hF);
    idle_in(); out_en_n = 1; addr = 8'h07; tick();
    out_en_n = 0; #1; check_out();
    idle_in(); out_en_n = 1; addr = 8'h08; tick();
    desel_op(0); desel_op(0);

    // R5 and R13: strict alternation of writes and reads
    cur_req = "R13";
    for (int k = 0; k < 40; k++) begin
      load_op(0, 8'(k % 5), 4'($urandom));
      load_op(1, 8'((k + 2) % 5), 4'hF);
    end
    cur_req = "R5";
    for (int k = 0; k < 20; k++) load_op(0, 8'(k), 4'hF);

    // Random mix over a small address pool
    cur_req = "R1";
    for (int k = 0; k < 4000; k++) begin
      int r = int'($urandom % 100);
      idle_in();
      addr      = {4'h5, 4'($urandom)};
      rnw       = 1'($urandom);
      lane_we_n = 4'($urandom);
      out_en_n  = ($urandom % 10) == 0;
      stall     = ($urandom % 10) == 0;
      adv       = r < 40;
      if (!adv) lin_order = 1'($urandom);
      if (!adv && ($urandom % 7) == 0) begin
        case ($urandom % 3)
          0: cs_a_n = 1;
          1: cs_b_n = 1;
          default: cs_c = 0;
        endcase
      end
      if (adv && $urandom % 3 == 0) cs_c = 0;
      tick();
    end
    desel_op(0); desel_op(0); desel_op(0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule